// File: doc/BRIEF.md
# SPI Pin Router with Slave-Select and Mode-Fault Control

This block sits between an SPI shift engine and the four serial pins: clock, master-out, master-in and slave-select. From a handful of configuration bits (role, slave-select output enable, slave-select direction, single-wire enable and single-wire direction), it decides which pins drive, which are sampled, and what each carries. The shift engine reports a busy flag, its serial clock and its outgoing bit. The router returns the received bit, the sampled pin clock, a slave-select indication and the role the engine should act in.

The slave-select pin can work in four ways. It can be an automatic chip-select that is low for each transfer. It can be a plain output driven from a port bit. It can be an input that watches for a second master, or it can be an ordinary input. When the block is master and another device pulls the watched slave-select low, the block raises a sticky mode-fault flag and falls back to slave behaviour until software clears the flag. In single-wire (half-duplex) operation, one data pin carries both directions and the other is released as a general-purpose pin. The master uses the master-out pin and the slave uses the master-in pin.

Each pin is modelled as separate output value, output enable and input signals. A pin's output value is meaningful only while its enable is 1.

Top module: `spi_pin_router`

## Requirements
- R1: With the effective role master, ss_dir=1 and ss_oe_cfg=1, ss_oe is 1 and ss_o is 0 while eng_busy=1 and 1 while eng_busy=0.
- R2: With the effective role master, ss_dir=1 and ss_oe_cfg=0, ss_oe is 1 and ss_o follows port_ss_val.
- R3: With the effective role master and ss_dir=0, ss_oe is 0 for either value of ss_oe_cfg. The combination ss_dir=0 with ss_oe_cfg=1 never sets the mode fault.
- R4: With the effective role slave, ss_oe is 0 whatever the direction and enable bits are, and eng_ss_sel equals the inverse of ss_i. With the effective role master, eng_ss_sel is 0.
- R5: When cfg_master=1, mode_fault=0, ss_dir=0, ss_oe_cfg=0 and ss_i=0 at a rising clock edge, mode_fault is 1 after that edge. mode_fault then holds until a rising edge with mf_clear=1, which returns it to 0. If set and clear coincide, set wins.
- R6: The effective role is cfg_master AND NOT mode_fault, and it is driven on eng_master. While mode_fault=1, sck_oe and ss_oe are 0 and all routing follows the slave rules.
- R7: With the effective role master, sck_oe=1 and sck_o=eng_sck. With the role slave, sck_oe=0. eng_sck_in always equals sck_i.
- R8: With single-wire off and role master: mosi_oe=1, mosi_o=eng_tx, miso_oe=0, eng_rx=miso_i and gpio_rx=0.
- R9: With single-wire off and role slave: mosi_oe=0, eng_rx=mosi_i, miso_o=eng_tx, miso_oe is the inverse of ss_i (drive only while selected), and gpio_rx=0.
- R10: With single-wire on and role master: mosi_oe=cfg_sw_dir, mosi_o=eng_tx, eng_rx=mosi_i. The MISO pin is general-purpose: miso_oe=port_gpio_dir, miso_o=port_gpio_val and gpio_rx=miso_i.
- R11: With single-wire on and role slave: miso_oe=cfg_sw_dir, miso_o=eng_tx, eng_rx=miso_i. The MOSI pin is general-purpose: mosi_oe=port_gpio_dir, mosi_o=port_gpio_val and gpio_rx=mosi_i.
- R12: While rst_n is low, mode_fault is 0, even with fault-setting inputs present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_master | input | 1 | 1 selects master role |
| cfg_ss_oe | input | 1 | Slave-select output enable |
| cfg_ss_dir | input | 1 | Slave-select pin direction bit (1 = output) |
| cfg_bidir | input | 1 | Single-wire (half-duplex) enable |
| cfg_sw_dir | input | 1 | Direction of the shared single-wire pin (1 = drive) |
| port_ss_val | input | 1 | Port value driven on SS when it is a general-purpose output |
| port_gpio_val | input | 1 | Value driven on the released data pin |
| port_gpio_dir | input | 1 | Direction of the released data pin (1 = drive) |
| mf_clear | input | 1 | Clears the mode-fault flag at a clock edge |
| eng_busy | input | 1 | Shift engine transfer in progress |
| eng_sck | input | 1 | Serial clock from the engine |
| eng_tx | input | 1 | Outgoing serial bit from the engine |
| eng_rx | output | 1 | Incoming serial bit to the engine |
| eng_sck_in | output | 1 | Sampled pin clock for the engine |
| eng_ss_sel | output | 1 | Slave selected (slave role, SS low) |
| eng_master | output | 1 | Effective master role |
| mode_fault | output | 1 | Sticky mode-fault flag |
| gpio_rx | output | 1 | Value read from the released data pin |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sck_i | input | 1 | Clock pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI pin output enable |
| mosi_i | input | 1 | MOSI pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO pin output enable |
| miso_i | input | 1 | MISO pin input |
| ss_o | output | 1 | SS pin output value |
| ss_oe | output | 1 | SS pin output enable |
| ss_i | input | 1 | SS pin input |

## Verification
The bench sweeps every combination of the configuration bits, pin inputs, engine inputs and the clear strobe. It tracks the fault flag alongside, so fault entry, fault clearing and the behaviour while faulted are all reached from many configurations.

- **Reserved slave-select setting.** A design that treated it as the watched input would raise faults that should never appear.
- **Routing while faulted.** A design that gated only the clock with the fault would keep driving MOSI or SS while faulted.
- **Set and clear in the same cycle.** A design that gave clear priority would lose a fault.
- **Shared-pin choice.** A design that picked the shared pin from the configured role instead of the effective role would drive the wrong data pin in single-wire operation.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

  typedef enum logic [2:0] {
    SS_SLV_IN   = 3'd0,
    SS_FAULT_IN = 3'd1,
    SS_RSV_IN   = 3'd2,
    SS_GP_OUT   = 3'd3,
    SS_AUTO_OUT = 3'd4
  } ss_fn_e;

  function automatic ss_fn_e ss_decode(input logic master, input logic oe, input logic dir);
    ss_fn_e fn;
    if (!master) begin
      fn = SS_SLV_IN;
    end else begin
      unique case ({dir, oe})
        2'b00:   fn = SS_FAULT_IN;
        2'b01:   fn = SS_RSV_IN;
        2'b10:   fn = SS_GP_OUT;
        default: fn = SS_AUTO_OUT;
      endcase
    end
    return fn;
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl
  import spi_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic cfg_ss_oe,
  input  logic cfg_ss_dir,
  input  logic port_ss_val,
  input  logic eng_busy,
  input  logic mf_clear,
  input  logic ss_i,
  output logic ss_o,
  output logic ss_oe,
  output logic ss_sel,
  output logic eff_master,
  output logic mode_fault
);
  ss_fn_e ss_fn;
  logic   mf_q, mf_d, mf_set, mf_en;

  assign eff_master = cfg_master & ~mf_q;
  assign ss_fn      = ss_decode(eff_master, cfg_ss_oe, cfg_ss_dir);

  // fault next-state: set dominates clear
  always_comb begin
    mf_set = (ss_fn == SS_FAULT_IN) & ~ss_i;
    mf_en  = mf_set | mf_clear;
    mf_d   = mf_q;
    if (mf_set)        mf_d = 1'b1;
    else if (mf_clear) mf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mf_q <= 1'b0;
    else if (mf_en) mf_q <= mf_d;
  end

  always_comb begin
    ss_oe = 1'b0;
    ss_o  = 1'b1;
    unique case (ss_fn)
      SS_GP_OUT:   begin ss_oe = 1'b1; ss_o = port_ss_val; end
      SS_AUTO_OUT: begin ss_oe = 1'b1; ss_o = ~eng_busy;   end
      default:     begin ss_oe = 1'b0; ss_o = 1'b1;        end
    endcase
  end

  assign ss_sel     = (ss_fn == SS_SLV_IN) & ~ss_i;
  assign mode_fault = mf_q;

  a_r5_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !mode_fault && !cfg_ss_dir && !cfg_ss_oe && !ss_i) |=> mode_fault);
  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !mf_clear) |=> mode_fault);
  a_r3_reserved_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_fault && cfg_ss_oe) |=> !mode_fault);
  a_r1_auto_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_master && cfg_ss_dir && cfg_ss_oe && eng_busy) |-> (ss_oe && !ss_o));
  a_r4_slave_ss_input: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_master |-> !ss_oe);
endmodule

// File: rtl/spi_data_route.sv
module spi_data_route (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_master,
  input  logic cfg_bidir,
  input  logic cfg_sw_dir,
  input  logic port_gpio_val,
  input  logic port_gpio_dir,
  input  logic eng_sck,
  input  logic eng_tx,
  input  logic ss_sel,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic miso_i,
  output logic sck_o,
  output logic sck_oe,
  output logic eng_sck_in,
  output logic mosi_o,
  output logic mosi_oe,
  output logic miso_o,
  output logic miso_oe,
  output logic eng_rx,
  output logic gpio_rx
);
  assign sck_oe     = eff_master;
  assign sck_o      = eff_master & eng_sck;
  assign eng_sck_in = sck_i;

  always_comb begin
    mosi_o  = 1'b0;
    mosi_oe = 1'b0;
    miso_o  = 1'b0;
    miso_oe = 1'b0;
    eng_rx  = 1'b0;
    gpio_rx = 1'b0;
    unique case ({cfg_bidir, eff_master})
      2'b01: begin                       // two-wire master
        mosi_oe = 1'b1;
        mosi_o  = eng_tx;
        eng_rx  = miso_i;
      end
      2'b00: begin                       // two-wire slave
        miso_oe = ss_sel;
        miso_o  = eng_tx;
        eng_rx  = mosi_i;
      end
      2'b11: begin                       // single-wire master on MOSI
        mosi_oe = cfg_sw_dir;
        mosi_o  = eng_tx;
        eng_rx  = mosi_i;
        miso_oe = port_gpio_dir;
        miso_o  = port_gpio_val;
        gpio_rx = miso_i;
      end
      default: begin                     // single-wire slave on MISO
        miso_oe = cfg_sw_dir;
        miso_o  = eng_tx;
        eng_rx  = miso_i;
        mosi_oe = port_gpio_dir;
        mosi_o  = port_gpio_val;
        gpio_rx = mosi_i;
      end
    endcase
  end

  a_r7_slave_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_master |-> !sck_oe);
  a_r9_slave_mosi_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bidir && !eff_master) |-> !mosi_oe);
  a_r10_shared_receive: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bidir && eff_master && !cfg_sw_dir) |-> !mosi_oe);
  a_r11_shared_receive: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bidir && !eff_master && !cfg_sw_dir) |-> !miso_oe);
endmodule

// File: rtl/spi_pin_router.sv
module spi_pin_router #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic cfg_ss_oe,
  input  logic cfg_ss_dir,
  input  logic cfg_bidir,
  input  logic cfg_sw_dir,
  input  logic port_ss_val,
  input  logic port_gpio_val,
  input  logic port_gpio_dir,
  input  logic mf_clear,
  input  logic eng_busy,
  input  logic eng_sck,
  input  logic eng_tx,
  output logic eng_rx,
  output logic eng_sck_in,
  output logic eng_ss_sel,
  output logic eng_master,
  output logic mode_fault,
  output logic gpio_rx,
  output logic sck_o,
  output logic sck_oe,
  input  logic sck_i,
  output logic mosi_o,
  output logic mosi_oe,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe,
  input  logic miso_i,
  output logic ss_o,
  output logic ss_oe,
  input  logic ss_i
);
  logic rst_n_s;
  logic eff_master;

  spi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  spi_ss_ctrl u_ss (
    .clk(clk), .rst_n(rst_n_s),
    .cfg_master(cfg_master), .cfg_ss_oe(cfg_ss_oe), .cfg_ss_dir(cfg_ss_dir),
    .port_ss_val(port_ss_val), .eng_busy(eng_busy), .mf_clear(mf_clear),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe), .ss_sel(eng_ss_sel),
    .eff_master(eff_master), .mode_fault(mode_fault)
  );

  spi_data_route u_route (
    .clk(clk), .rst_n(rst_n_s),
    .eff_master(eff_master), .cfg_bidir(cfg_bidir), .cfg_sw_dir(cfg_sw_dir),
    .port_gpio_val(port_gpio_val), .port_gpio_dir(port_gpio_dir),
    .eng_sck(eng_sck), .eng_tx(eng_tx), .ss_sel(eng_ss_sel),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .eng_sck_in(eng_sck_in),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_o(miso_o), .miso_oe(miso_oe),
    .eng_rx(eng_rx), .gpio_rx(gpio_rx)
  );

  assign eng_master = eff_master;

  a_r6_fault_releases_master: assert property (@(posedge clk) disable iff (!rst_n_s)
    mode_fault |-> (!sck_oe && !ss_oe && !eng_master));
  a_r12_reset_clear: assert property (@(posedge clk)
    !rst_n |-> !mode_fault);
endmodule

// File: tb/test_spi_pin_router.sv
module test_spi_pin_router;
  localparam time CLK_P = 20ns;

  logic clk, rst_n;
  logic cfg_master, cfg_ss_oe, cfg_ss_dir, cfg_bidir, cfg_sw_dir;
  logic port_ss_val, port_gpio_val, port_gpio_dir, mf_clear;
  logic eng_busy, eng_sck, eng_tx;
  logic eng_rx, eng_sck_in, eng_ss_sel, eng_master, mode_fault, gpio_rx;
  logic sck_o, sck_oe, sck_i, mosi_o, mosi_oe, mosi_i;
  logic miso_o, miso_oe, miso_i, ss_o, ss_oe, ss_i;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic f_mdl;

  spi_pin_router i_spi_pin_router (
    .clk(clk), .rst_n(rst_n),
    .cfg_master(cfg_master), .cfg_ss_oe(cfg_ss_oe), .cfg_ss_dir(cfg_ss_dir),
    .cfg_bidir(cfg_bidir), .cfg_sw_dir(cfg_sw_dir),
    .port_ss_val(port_ss_val), .port_gpio_val(port_gpio_val), .port_gpio_dir(port_gpio_dir),
    .mf_clear(mf_clear), .eng_busy(eng_busy), .eng_sck(eng_sck), .eng_tx(eng_tx),
    .eng_rx(eng_rx), .eng_sck_in(eng_sck_in), .eng_ss_sel(eng_ss_sel),
    .eng_master(eng_master), .mode_fault(mode_fault), .gpio_rx(gpio_rx),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
    .ss_o(ss_o), .ss_oe(ss_oe), .ss_i(ss_i)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cfg m%b oe%b dir%b bi%b swd%b f%b)",
               req, what, act, exp, cfg_master, cfg_ss_oe, cfg_ss_dir, cfg_bidir, cfg_sw_dir, f_mdl);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    {cfg_master, cfg_ss_oe, cfg_ss_dir, cfg_bidir, cfg_sw_dir, port_ss_val,
     port_gpio_val, port_gpio_dir, mf_clear, eng_busy, eng_sck, eng_tx,
     sck_i, mosi_i, miso_i, ss_i} = v;
  endtask

  task automatic check_all();
    logic  eff;
    string ts, tc, td;
    eff = cfg_master & ~f_mdl;
    if (cfg_master && f_mdl) ts = "R6";
    else if (!eff)           ts = "R4";
    else if (cfg_ss_dir && cfg_ss_oe) ts = "R1";
    else if (cfg_ss_dir)     ts = "R2";
    else                     ts = "R3";
    tc = (cfg_master && f_mdl) ? "R6" : "R7";
    if (cfg_bidir) td = eff ? "R10" : "R11";
    else           td = eff ? "R8"  : "R9";

    chk("R5", "mode_fault", mode_fault, f_mdl);
    chk("R6", "eng_master", eng_master, eff);
    // slave-select
    chk(ts, "ss_oe", ss_oe, eff & cfg_ss_dir);
    if (eff && cfg_ss_dir) chk(ts, "ss_o", ss_o, cfg_ss_oe ? ~eng_busy : port_ss_val);
    chk("R4", "eng_ss_sel", eng_ss_sel, ~eff & ~ss_i);
    // clock
    chk(tc, "sck_oe", sck_oe, eff);
    if (eff) chk(tc, "sck_o", sck_o, eng_sck);
    chk("R7", "eng_sck_in", eng_sck_in, sck_i);
    // data
    if (!cfg_bidir && eff) begin
      chk(td, "mosi_oe", mosi_oe, 1'b1);
      chk(td, "mosi_o", mosi_o, eng_tx);
      chk(td, "miso_oe", miso_oe, 1'b0);
      chk(td, "eng_rx", eng_rx, miso_i);
      chk(td, "gpio_rx", gpio_rx, 1'b0);
    end else if (!cfg_bidir) begin
      chk(td, "mosi_oe", mosi_oe, 1'b0);
      chk(td, "miso_oe", miso_oe, ~ss_i);
      if (!ss_i) chk(td, "miso_o", miso_o, eng_tx);
      chk(td, "eng_rx", eng_rx, mosi_i);
      chk(td, "gpio_rx", gpio_rx, 1'b0);
    end else if (eff) begin
      chk(td, "mosi_oe", mosi_oe, cfg_sw_dir);
      if (cfg_sw_dir) chk(td, "mosi_o", mosi_o, eng_tx);
      chk(td, "eng_rx", eng_rx, mosi_i);
      chk(td, "miso_oe", miso_oe, port_gpio_dir);
      if (port_gpio_dir) chk(td, "miso_o", miso_o, port_gpio_val);
      chk(td, "gpio_rx", gpio_rx, miso_i);
    end else begin
      chk(td, "miso_oe", miso_oe, cfg_sw_dir);
      if (cfg_sw_dir) chk(td, "miso_o", miso_o, eng_tx);
      chk(td, "eng_rx", eng_rx, miso_i);
      chk(td, "mosi_oe", mosi_oe, port_gpio_dir);
      if (port_gpio_dir) chk(td, "mosi_o", mosi_o, port_gpio_val);
      chk(td, "gpio_rx", gpio_rx, mosi_i);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    f_mdl = 1'b0;
    // fault-setting stimulus held during reset: R12
    apply(16'h8000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "mode_fault in reset", mode_fault, 1'b0);
    apply(16'h0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "mode_fault after reset", mode_fault, 1'b0);

    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      apply(i[15:0]);
      #2ns;
      check_all();
      @(posedge clk);
      // fault model, set wins over clear (R5, R3)
      if (cfg_master && !f_mdl && !cfg_ss_dir && !cfg_ss_oe && !ss_i) f_mdl = 1'b1;
      else if (mf_clear) f_mdl = 1'b0;
    end
    @(negedge clk);
    chk("R5", "final mode_fault", mode_fault, f_mdl);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule